// File: doc/BRIEF.md
# Flash Mode Control Register

This block is the single control and status register that stands between a CPU and an on-chip flash. Software reads a live ready flag from the flash command sequencer, opens the path for flash commands through a two-step write sequence, can hold the flash controller in reset, and picks whether the top of the address map shows the boot area or the user area. The register sits at one even bus address. Only the low byte of a write is used. Reads return bits that have no function as 0.

The block has two small state machines. The mode latch holds `MODE_WAIT` from reset. On the first clock after reset release it moves to `MODE_BOOT` or `MODE_USER`, and it keeps that state until the next reset. The unlock machine has the states `UL_LOCKED`, `UL_ARMED` and `UL_OPEN`. A register write with bit 1 = 0 moves any state to `UL_ARMED`. A write with bit 1 = 1 moves `UL_ARMED` to `UL_OPEN`, keeps `UL_OPEN` in `UL_OPEN`, and leaves `UL_LOCKED` where it is. A synchronous clear returns the machine to `UL_LOCKED`.

A combinational decoder tells the fetch path whether a CPU address falls in the boot window and gives the offset into that window. The synchronous clear is the combined watchdog and software reset.

Top module: `flash_mode_ctl`

## Requirements
- R1: Register bit 0 reads 1 when `seq_busy` is low and 0 when it is high, in the same cycle.
- R2: Register bit 1 (and `cmd_en`) becomes 1 only when a register write with bit 1 = 1 directly follows a register write with bit 1 = 0. A lone write of 1 after reset leaves it at 0.
- R3: A single register write with bit 1 = 0 clears bit 1 and `cmd_en` on the next cycle.
- R4: A write of 1 to bit 3 sets it, and drives `ctl_rst`, only if bit 1 was already 1 before that write. A write of 0 to bit 3 always clears it.
- R5: In boot mode with bit 5 = 0, a fetch address from 0xE000 to 0xFFFF raises `fetch_boot` and gives `fetch_ofs` = address − 0xE000. With bit 5 = 1, `fetch_boot` is 0, `fetch_ofs` equals the address and `area_user` is 1.
- R6: In normal mode, bit 5 has no effect: `fetch_boot` stays 0 and `area_user` stays 1 for every address.
- R7: After reset a register read returns 0x0001 while the sequencer is idle. Bits 15:6, 4 and 2 always read 0.
- R8: `sync_clr` returns bits 1, 3 and 5 to 0 and locks the unlock machine. It wins over a register write in the same cycle and leaves the mode unchanged.
- R9: On the first clock after reset release, `md0`=0 with `md1`=1 selects boot mode and every other pin pair selects normal mode. Later changes on the pins are ignored.
- R10: Writes to any address other than `REG_ADDR` leave the register unchanged, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (reset pin) |
| sync_clr | input | 1 | Synchronous clear from watchdog or software reset |
| md0 | input | 1 | Mode pin 0 |
| md1 | input | 1 | Mode pin 1 |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Write data, low byte |
| bus_rdata | output | 16 | Read data |
| seq_busy | input | 1 | Command sequencer busy |
| fetch_addr | input | ADDR_W | CPU fetch address |
| fetch_boot | output | 1 | Fetch address maps to the boot area |
| fetch_ofs | output | ADDR_W | Offset into the selected area |
| area_user | output | 1 | User area is mapped at the top of memory |
| boot_mode | output | 1 | Chip started in boot mode |
| cmd_en | output | 1 | Flash commands are accepted |
| ctl_rst | output | 1 | Flash controller held in reset |

## Verification
Two events can fall in the same cycle: a register write that would set the enable and reset bits, and a `sync_clr`. The bench drives both on one clock edge while the register is already open. It then requires that the register reads 0x0001, that `cmd_en` and `ctl_rst` are low, and that the boot mode is unchanged. A second collision puts a write of 1 to bit 3 on the same edge as the write that opens bit 1. Bit 3 must stay 0 there, because the gate uses the enable value from before the edge.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
    typedef enum logic [1:0] {
        MODE_WAIT = 2'd0,
        MODE_USER = 2'd1,
        MODE_BOOT = 2'd2
    } start_mode_e;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_ARMED  = 2'd1,
        UL_OPEN   = 2'd2
    } unlock_e;

    localparam int BIT_RDY  = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_FRST = 3;
    localparam int BIT_USEL = 5;
endpackage

// File: rtl/fmc_mode_latch.sv
module fmc_mode_latch
    import fmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        md0,
    input  logic        md1,
    output start_mode_e mode_o,
    output logic        is_boot_o
);
    start_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_WAIT: state_d = (!md0 && md1) ? MODE_BOOT : MODE_USER;
            MODE_USER: state_d = MODE_USER;
            MODE_BOOT: state_d = MODE_BOOT;
            default:   state_d = MODE_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_o    = state_q;
        is_boot_o = (state_q == MODE_BOOT);
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MODE_WAIT) |=> (state_q == $past(state_q))) else $error("mode changed"); // R9
endmodule

// File: rtl/fmc_unlock.sv
module fmc_unlock
    import fmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic en_o
);
    unlock_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = UL_LOCKED;
        end else if (wr_hit) begin
            unique case (state_q)
                UL_LOCKED: state_d = wr_bit ? UL_LOCKED : UL_ARMED;
                UL_ARMED:  state_d = wr_bit ? UL_OPEN   : UL_ARMED;
                UL_OPEN:   state_d = wr_bit ? UL_OPEN   : UL_ARMED;
                default:   state_d = UL_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb en_o = (state_q == UL_OPEN);

    AST_OPEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_bit && !clr && state_q == UL_LOCKED) |=> !en_o) else $error("unlock skipped"); // R2
endmodule

// File: rtl/fmc_region.sv
module fmc_region #(
    parameter int                ADDR_W    = 16,
    parameter int                BOOT_LOG2 = 13,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hE000
) (
    input  logic              boot_mode_i,
    input  logic              usel_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              boot_hit_o,
    output logic              user_area_o,
    output logic [ADDR_W-1:0] ofs_o
);
    localparam int                TAG_W    = ADDR_W - BOOT_LOG2;
    localparam logic [TAG_W-1:0]  BOOT_TAG = BOOT_BASE[ADDR_W-1:BOOT_LOG2];
    localparam logic [ADDR_W-1:0] OFS_MASK = (ADDR_W'(1) << BOOT_LOG2) - ADDR_W'(1);

    logic in_window;

    always_comb begin
        in_window   = (fetch_addr_i[ADDR_W-1:BOOT_LOG2] == BOOT_TAG);
        user_area_o = !boot_mode_i || usel_i;
        boot_hit_o  = !user_area_o && in_window;
        ofs_o       = boot_hit_o ? (fetch_addr_i & OFS_MASK) : fetch_addr_i;
    end
endmodule

// File: rtl/flash_mode_ctl.sv
module flash_mode_ctl
    import fmc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h009E,
    parameter int                BOOT_LOG2 = 13,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              md0,
    input  logic              md1,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              seq_busy,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_boot,
    output logic [ADDR_W-1:0] fetch_ofs,
    output logic              area_user,
    output logic              boot_mode,
    output logic              cmd_en,
    output logic              ctl_rst
);
    start_mode_e mode;
    logic        is_boot;
    logic        reg_hit, wr_hit;
    logic        en;
    logic        frst_q, usel_q;
    logic [7:0]  reg_val;
    logic [4:0]  wdata_unused;

    always_comb begin
        reg_hit      = (bus_addr == REG_ADDR);
        wr_hit       = bus_wr && reg_hit;
        wdata_unused = {bus_wdata[7:6], bus_wdata[4], bus_wdata[2], bus_wdata[0]};
    end

    fmc_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .md0       (md0),
        .md1       (md1),
        .mode_o    (mode),
        .is_boot_o (is_boot)
    );

    fmc_unlock u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sync_clr),
        .wr_hit (wr_hit),
        .wr_bit (bus_wdata[BIT_EN]),
        .en_o   (en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frst_q <= 1'b0;
            usel_q <= 1'b0;
        end else if (sync_clr) begin
            frst_q <= 1'b0;
            usel_q <= 1'b0;
        end else if (wr_hit) begin
            usel_q <= bus_wdata[BIT_USEL];
            if (!bus_wdata[BIT_FRST]) frst_q <= 1'b0;
            else if (en)              frst_q <= 1'b1;
        end
    end

    fmc_region #(
        .ADDR_W    (ADDR_W),
        .BOOT_LOG2 (BOOT_LOG2),
        .BOOT_BASE (BOOT_BASE)
    ) u_region (
        .boot_mode_i  (is_boot),
        .usel_i       (usel_q),
        .fetch_addr_i (fetch_addr),
        .boot_hit_o   (fetch_boot),
        .user_area_o  (area_user),
        .ofs_o        (fetch_ofs)
    );

    always_comb begin
        reg_val           = 8'h00;
        reg_val[BIT_RDY]  = !seq_busy;
        reg_val[BIT_EN]   = en;
        reg_val[BIT_FRST] = frst_q;
        reg_val[BIT_USEL] = usel_q;
        bus_rdata         = reg_hit ? {8'h00, reg_val} : 16'h0000;
        boot_mode         = is_boot;
        cmd_en            = en;
        ctl_rst           = frst_q;
    end

    AST_FRST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rst) |-> $past(cmd_en)) else $error("reset bit set while locked"); // R4
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (!cmd_en && !ctl_rst)) else $error("clear lost"); // R8
    AST_USER_NO_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_USER) |-> (!fetch_boot && area_user)) else $error("boot hit in normal mode"); // R6
    AST_CLR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_clr && mode != MODE_WAIT) |=> $stable(boot_mode)) else $error("mode lost on clear"); // R8
endmodule

// File: tb/flash_mode_ctl_test.sv
module flash_mode_ctl_test;
    localparam logic [15:0] REG = 16'h009E;

    logic        clk = 0, rst_n = 0, sync_clr = 0, md0 = 0, md1 = 0;
    logic [15:0] bus_addr = REG;
    logic        bus_wr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        seq_busy = 0;
    logic [15:0] fetch_addr = 0;
    logic        fetch_boot, area_user, boot_mode, cmd_en, ctl_rst;
    logic [15:0] fetch_ofs;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_mode_ctl uut (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .md0(md0), .md1(md1),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_busy(seq_busy), .fetch_addr(fetch_addr), .fetch_boot(fetch_boot),
        .fetch_ofs(fetch_ofs), .area_user(area_user), .boot_mode(boot_mode),
        .cmd_en(cmd_en), .ctl_rst(ctl_rst)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic p0, logic p1);
        @(negedge clk);
        rst_n = 0; md0 = p0; md1 = p1; bus_wr = 0; sync_clr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_addr = REG;
    endtask

    task automatic rd_chk(string req, logic [15:0] exp);
        bus_addr = REG; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic t_reset_value;
        do_reset(0, 0);
        rd_chk("R7 reset value", 16'h0001);
        chk("R7 cmd_en after reset", {15'd0, cmd_en}, 16'd0);
        chk("R9 normal mode 00", {15'd0, boot_mode}, 16'd0);
    endtask

    task automatic t_ready;
        seq_busy = 1; rd_chk("R1 busy reads 0", 16'h0000);
        seq_busy = 0; rd_chk("R1 idle reads 1", 16'h0001);
    endtask

    task automatic t_unlock;
        wr(REG, 8'h02);
        chk("R2 lone 1 ignored", {15'd0, cmd_en}, 16'd0);
        wr(REG, 8'h00); wr(REG, 8'h02);
        chk("R2 0 then 1 opens", {15'd0, cmd_en}, 16'd1);
        rd_chk("R2 readback", 16'h0003);
        wr(REG, 8'h00);
        chk("R3 write 0 clears", {15'd0, cmd_en}, 16'd0);
        wr(REG, 8'h00); wr(REG, 8'h00); wr(REG, 8'h02);
        chk("R2 reopen after zeros", {15'd0, cmd_en}, 16'd1);
    endtask

    task automatic t_frst;
        wr(REG, 8'h00);
        wr(REG, 8'h08);
        chk("R4 bit3 ignored while locked", {15'd0, ctl_rst}, 16'd0);
        wr(REG, 8'h0A);
        chk("R4 same edge as unlock", {15'd0, ctl_rst}, 16'd0);
        wr(REG, 8'h0A);
        chk("R4 bit3 set when open", {15'd0, ctl_rst}, 16'd1);
        rd_chk("R4 readback", 16'h000B);
        wr(REG, 8'h02);
        chk("R4 write 0 clears bit3", {15'd0, ctl_rst}, 16'd0);
    endtask

    task automatic t_clr_collide;
        wr(REG, 8'h0A);
        bus_addr = REG; bus_wdata = 8'h2A; bus_wr = 1; sync_clr = 1;
        @(negedge clk);
        bus_wr = 0; sync_clr = 0;
        rd_chk("R8 clear beats write", 16'h0001);
        chk("R8 cmd_en low", {15'd0, cmd_en}, 16'd0);
        chk("R8 ctl_rst low", {15'd0, ctl_rst}, 16'd0);
    endtask

    task automatic t_boot;
        do_reset(0, 1);
        chk("R9 boot mode 01", {15'd0, boot_mode}, 16'd1);
        fetch_addr = 16'hE123; #1;
        chk("R5 boot hit", {15'd0, fetch_boot}, 16'd1);
        chk("R5 boot offset", fetch_ofs, 16'h0123);
        chk("R5 area boot", {15'd0, area_user}, 16'd0);
        fetch_addr = 16'h8000; #1;
        chk("R5 outside window", {15'd0, fetch_boot}, 16'd0);
        chk("R5 outside offset", fetch_ofs, 16'h8000);
        wr(REG, 8'h20);
        fetch_addr = 16'hE123; #1;
        chk("R5 user select", {15'd0, fetch_boot}, 16'd0);
        chk("R5 user offset", fetch_ofs, 16'hE123);
        chk("R5 area user", {15'd0, area_user}, 16'd1);
        md0 = 1; md1 = 0;
        repeat (3) @(negedge clk);
        chk("R9 pins ignored later", {15'd0, boot_mode}, 16'd1);
        sync_clr = 1; @(negedge clk); sync_clr = 0; #1;
        chk("R8 mode kept", {15'd0, boot_mode}, 16'd1);
        chk("R8 usel cleared", {15'd0, fetch_boot}, 16'd1);
    endtask

    task automatic t_user;
        do_reset(0, 0);
        fetch_addr = 16'hE000; #1;
        chk("R6 normal no boot hit", {15'd0, fetch_boot}, 16'd0);
        chk("R6 normal area user", {15'd0, area_user}, 16'd1);
        chk("R6 normal offset", fetch_ofs, 16'hE000);
        wr(REG, 8'h20); #1;
        chk("R6 usel no effect", {15'd0, fetch_boot}, 16'd0);
        do_reset(1, 1);
        chk("R9 pins 11 normal", {15'd0, boot_mode}, 16'd0);
    endtask

    task automatic t_addr;
        do_reset(0, 0);
        wr(16'h009C, 8'h00);
        wr(REG, 8'h02);
        chk("R10 foreign write ignored", {15'd0, cmd_en}, 16'd0);
        wr(16'h009F, 8'h20);
        rd_chk("R10 foreign usel ignored", 16'h0001);
        bus_addr = 16'h009C; #1;
        chk("R10 foreign read zero", bus_rdata, 16'h0000);
        bus_addr = REG;
    endtask

    initial begin
        t_reset_value();
        t_ready();
        t_unlock();
        t_frst();
        t_clr_collide();
        t_boot();
        t_user();
        t_addr();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule